// File: doc/BRIEF.md
# Ephemeral history register

This block is a storage element of parameterised width that exposes a fixed number of ordered access ports. Every port has a read output, a write enable and write data. Inside one clock cycle the ports act in a fixed sequence: port 0 reads, then port 0 may write, then port 1 reads, then port 1 may write, and so on. A read on a given port therefore sees the newest value written by any lower-numbered port during the same cycle, and the state captured at the clock edge is the outcome of the whole sequence.

Such a register lets several logically ordered operations on one piece of state complete in a single cycle without arbitration. A typical use is an up/down counter where the increment path uses port 0 and the decrement path uses port 1: when both fire together, the decrement observes the incremented value and the net change is zero. An extra output gives the value that the sequence will commit at the next edge, so a consumer can read "after all ports" as well.

Top module: `ehr_reg`

## Requirements
- R1: Reset is synchronous and active low; a clock edge with `rst_n` low loads the parameter `RESET_VAL` into the stored value and every write enable is ignored at that edge.
- R2: Read port 0 (`rd_data` bits `[WIDTH-1:0]`) always shows the stored value and does not change with any write enable or write data in the current cycle.
- R3: For port i above 0 (slice `[i*WIDTH +: WIDTH]` of `rd_data`), the read shows the write data of the highest-numbered enabled port below i in the current cycle, or the stored value when no such port is enabled.
- R4: At a clock edge with `rst_n` high, the stored value becomes the write data of the highest-numbered enabled port (bit i of `wr_en` enables port i, data in `wr_data[i*WIDTH +: WIDTH]`).
- R5: At a clock edge with `rst_n` high and no write enable set, the stored value is held.
- R6: `commit_val` shows, in the current cycle, the value that will be stored at the next edge when `rst_n` is high: the data of the highest enabled port, or the stored value when none is enabled.
- R7: A 2-port up/down counter built on the register (increment reads and writes port 0, decrement reads and writes port 1, 8-bit wraparound) keeps its count when both are asserted in one cycle and moves by exactly one, modulo 256, when only one is asserted.
- R8: Width and port count are parameters; both a 2-port and a 3-port configuration over an 8-bit value obey R2 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | PORTS | Write enable, bit i for port i |
| wr_data | input | PORTS*WIDTH | Write data, port i in slice i |
| rd_data | output | PORTS*WIDTH | Read data, port i in slice i |
| commit_val | output | WIDTH | Value that the next edge stores |

## Verification
The hardest situation is a cycle where several ports write at once with different data, because only then does a read on a higher port have to choose the nearest lower writer rather than simply any writer or the stored value. Random enable masks over three ports with distinct random data make every combination of lower writers occur many times, and directed cycles add all-enabled, none-enabled and middle-only patterns. The counter harness reaches the simultaneous increment and decrement case, and the wrap below zero, by directed sequences.

// File: rtl/ehr_pkg.sv
// Package: ehr_pkg
// Shared defaults for the ordered-port register.
// Assumes: nothing; holds constants only.
package ehr_pkg;
    localparam int unsigned EHR_DEF_WIDTH = 8;
    localparam int unsigned EHR_DEF_PORTS = 3;
endpackage

// File: rtl/ehr_fwd_stage.sv
// Module: ehr_fwd_stage
// One link of the forwarding chain: passes the incoming value on unless
// this port writes, in which case its write data replaces it.
// Assumes: purely combinational, no state.
module ehr_fwd_stage #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] prev_val,
    input  logic             en,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] next_val
);
    // Select this port's write over the value handed down from lower ports.
    always_comb begin
        next_val = en ? data : prev_val;
    end
endmodule

// File: rtl/ehr_store.sv
// Module: ehr_store
// Holds the committed value across cycles.
// Assumes: synchronous active-low reset; d is the already-resolved value.
module ehr_store #(
    parameter int unsigned          WIDTH     = 8,
    parameter logic [WIDTH-1:0]     RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Capture the resolved value, or the reset constant.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end
endmodule

// File: rtl/ehr_reg.sv
// Module: ehr_reg
// Register with PORTS ordered access ports. Port i reads the value left by
// ports 0..i-1 in the current cycle; the edge stores the value left by all.
// Assumes: each port writes at most once per cycle (one enable bit each).
module ehr_reg
    import ehr_pkg::*;
#(
    parameter int unsigned      WIDTH     = EHR_DEF_WIDTH,
    parameter int unsigned      PORTS     = EHR_DEF_PORTS,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PORTS-1:0]       wr_en,
    input  logic [PORTS*WIDTH-1:0] wr_data,
    output logic [PORTS*WIDTH-1:0] rd_data,
    output logic [WIDTH-1:0]       commit_val
);
    localparam int unsigned CHAIN_LEN = PORTS + 1;

    logic [WIDTH-1:0] chain [CHAIN_LEN];
    logic [WIDTH-1:0] stored;

    // Committed state.
    ehr_store #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (chain[PORTS]),
        .q     (stored)
    );

    // Head of the chain is the stored value.
    always_comb begin
        chain[0] = stored;
    end

    // One forwarding stage and one read tap per port.
    for (genvar p = 0; p < PORTS; p++) begin : g_port
        assign rd_data[p*WIDTH +: WIDTH] = chain[p];

        ehr_fwd_stage #(.WIDTH(WIDTH)) stage_i (
            .prev_val (chain[p]),
            .en       (wr_en[p]),
            .data     (wr_data[p*WIDTH +: WIDTH]),
            .next_val (chain[p+1])
        );
    end

    assign commit_val = chain[PORTS];
endmodule

// File: rtl/ehr_reg_chk.sv
// Module: ehr_reg_chk
// Property checker for ehr_reg, attached by bind below.
// Assumes: observes ports only.
module ehr_reg_chk #(
    parameter int unsigned      WIDTH     = 8,
    parameter int unsigned      PORTS     = 3,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [PORTS-1:0]       wr_en,
    input logic [PORTS*WIDTH-1:0] wr_data,
    input logic [PORTS*WIDTH-1:0] rd_data,
    input logic [WIDTH-1:0]       commit_val
);
    // R1: a reset edge loads the reset constant whatever the enables.
    a_r1_reset_load: assert property (@(posedge clk)
        !rst_n |=> rd_data[WIDTH-1:0] == RESET_VAL);

    // R4: the port-0 view after an edge is what was due to commit.
    a_r4_commit: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rd_data[WIDTH-1:0] == $past(commit_val));

    // R5: no enables means the stored value holds.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == '0) |=> $stable(rd_data[WIDTH-1:0]));

    // R6: last port writing decides the committed value.
    a_r6_last_writer: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[PORTS-1] |-> commit_val == wr_data[(PORTS-1)*WIDTH +: WIDTH]);

    a_r6_pass_last: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en[PORTS-1] |-> commit_val == rd_data[(PORTS-1)*WIDTH +: WIDTH]);

    // R3: each higher read follows the port just below it.
    for (genvar p = 1; p < PORTS; p++) begin : g_fwd
        a_r3_fwd_taken: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[p-1] |-> rd_data[p*WIDTH +: WIDTH] == wr_data[(p-1)*WIDTH +: WIDTH]);
        a_r3_fwd_pass: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[p-1] |-> rd_data[p*WIDTH +: WIDTH] == rd_data[(p-1)*WIDTH +: WIDTH]);
    end
endmodule

bind ehr_reg ehr_reg_chk #(
    .WIDTH(WIDTH), .PORTS(PORTS), .RESET_VAL(RESET_VAL)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .commit_val (commit_val)
);

// File: tb/ehr_reg_tb_top.sv
// Bench for ehr_reg: a 3-port instance under random and directed stimulus,
// plus a 2-port up/down counter harness.
module ehr_reg_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  W          = 8;
    localparam int  NP         = 3;
    localparam logic [W-1:0] RV = 8'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NP-1:0]   wr_en   = '0;
    logic [NP*W-1:0] wr_data = '0;
    logic [NP*W-1:0] rd_data;
    logic [W-1:0]    commit_val;

    ehr_reg #(.WIDTH(W), .PORTS(NP), .RESET_VAL(RV)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .commit_val(commit_val)
    );

    // Counter harness (R7): increment on port 0, decrement on port 1.
    logic         c_inc = 1'b0, c_dec = 1'b0;
    logic [2*W-1:0] c_rd;
    logic [W-1:0]   c_commit;
    logic [W-1:0]   c_rd0, c_rd1, c_up, c_dn;
    assign c_rd0 = c_rd[W-1:0];
    assign c_rd1 = c_rd[2*W-1:W];
    assign c_up  = c_rd0 + 8'd1;
    assign c_dn  = c_rd1 - 8'd1;

    ehr_reg #(.WIDTH(W), .PORTS(2), .RESET_VAL('0)) cnt_i (
        .clk(clk), .rst_n(rst_n), .wr_en({c_dec, c_inc}), .wr_data({c_dn, c_up}),
        .rd_data(c_rd), .commit_val(c_commit)
    );

    int checks = 0, failures = 0;
    bit done = 1'b0;
    logic [W-1:0] model = '0;
    logic [W-1:0] cmodel = '0;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Expected read on port p: nearest enabled lower writer, else stored.
    function automatic logic [W-1:0] exp_read(input int p, input logic [NP-1:0] en,
                                              input logic [NP*W-1:0] d, input logic [W-1:0] st);
        logic [W-1:0] v = st;
        for (int j = 0; j < p; j++) if (en[j]) v = d[j*W +: W];
        return v;
    endfunction

    // Apply one cycle on the 3-port instance and check reads and commit.
    task automatic step(input logic [NP-1:0] en, input logic [NP*W-1:0] d);
        @(negedge clk);
        wr_en = en; wr_data = d;
        #1;
        chk("R2 port0", rd_data[W-1:0], model);
        for (int p = 1; p < NP; p++)
            chk("R3 fwd", rd_data[p*W +: W], exp_read(p, en, d, model));
        chk("R6 commit", commit_val, exp_read(NP, en, d, model));
        @(posedge clk);
        model = exp_read(NP, en, d, model);
        #1;
        if (en == '0) chk("R5 hold", rd_data[W-1:0], model);
        else          chk("R4 store", rd_data[W-1:0], model);
    endtask

    task automatic cstep(input logic inc, input logic dec);
        @(negedge clk);
        c_inc = inc; c_dec = dec;
        @(posedge clk);
        cmodel = cmodel + (inc ? 8'd1 : 8'd0) - (dec ? 8'd1 : 8'd0);
        #1;
        chk("R7 counter", c_rd0, cmodel);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(posedge clk);
        #1;
        chk("R1 reset", rd_data[W-1:0], RV);
        chk("R1 reset cnt", c_rd0, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        model = RV; cmodel = '0;

        // Directed patterns.
        step(3'b000, 24'h332211);
        step(3'b111, 24'hC3B2A1);
        step(3'b010, 24'h0F7E0D);
        step(3'b101, 24'h445566);
        step(3'b001, 24'h000099);
        step(3'b000, 24'hFFFFFF);

        // Random mixes, R8 on the 3-port configuration.
        for (int k = 0; k < 300; k++)
            step(3'($urandom), 24'($urandom));

        // R1: reset with every write enabled.
        @(negedge clk);
        rst_n = 1'b0; wr_en = '1; wr_data = 24'h123456;
        @(posedge clk); #1;
        chk("R1 reset ignores writes", rd_data[W-1:0], RV);
        @(negedge clk); rst_n = 1'b1; wr_en = '0;
        model = RV;
        step(3'b000, '0);

        // Counter harness: 2-port configuration.
        cmodel = c_rd0;
        cstep(1'b1, 1'b0);
        cstep(1'b1, 1'b0);
        cstep(1'b1, 1'b1);
        cstep(1'b0, 1'b1);
        cstep(1'b0, 1'b1);
        cstep(1'b0, 1'b1);   // wraps below zero
        cstep(1'b1, 1'b1);
        cstep(1'b0, 1'b0);
        for (int k = 0; k < 100; k++) cstep(1'($urandom), 1'($urandom));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule